// File: doc/BRIEF.md
# Basic-Rate ISDN Interchip Link Slave

This block is the slave end of a full-duplex basic-rate ISDN interchip link. The link master supplies a bit clock and a frame-sync pulse, and the block never generates timing of its own. Every 20 link-clock periods carry one frame holding two 8-bit bearer channels (B1, B2) and two bits of the signalling channel (D). The bit rate is 160 kbps in each direction. The block's system clock oversamples the link clock and acts only on the detected link-clock edges.

The receive section and the transmit section each have their own framing state machine. The receive section samples the data line on falling link-clock edges and delivers each finished B byte as a parallel word with a one-cycle valid pulse. It delivers the two D bits of a frame as one 2-bit group after the last bit of that frame. The transmit section launches bits on rising link-clock edges. Each of B1, B2 and the D pair is loaded through a one-entry staging register with a valid/ready handshake. A staged value is consumed at the next frame start. Several instances can serve independent links side by side because an instance shares nothing outside its own ports.

Both state machines use the states SL_WAIT, SL_B1, SL_D1, SL_B2, SL_D2 and SL_RSV. SL_WAIT is the reset state. It moves to SL_B1 on a sampled frame sync. SL_B1 moves to SL_D1 after its 8th bit, and SL_D1 moves to SL_B2 after one bit. SL_B2 moves to SL_D2 after its 8th bit, and SL_D2 moves to SL_RSV after one bit. SL_RSV returns to SL_WAIT after its 2nd bit. From any state, a frame sync moves the machine to bit 0 of SL_B1.

Top module: `idl_slave_if`

## Requirements
- R1: Frame bit order after the sync-marked bit 0 is: bits 0–7 B1 (MSB first), bit 8 first D bit, bits 9–16 B2 (MSB first), bit 17 second D bit, bits 18–19 reserved. Reserved bits are ignored on receive.
- R2: A received B1 or B2 byte appears on its data port together with a one-system-cycle valid pulse. The pulse is asserted in the cycle after the falling link-clock edge that sampled the byte's 8th bit.
- R3: The two received D bits appear as `d_rx_bits` = {bit 8, bit 17} with a one-cycle `d_rx_valid` after bit 19 of a complete frame. At most one receive valid is high in any cycle.
- R4: The transmit line carries the R1 layout with both reserved bits driven 1. It changes only in the cycle after a detected rising link-clock edge.
- R5: A transmit channel's ready is high while its staging register is empty. It drops in the cycle after a valid/ready transfer, and the staged value is sent in the next frame that starts, after which ready rises again.
- R6: A B channel with nothing staged at frame start is sent as 8'hFF. A D pair with nothing staged is sent as 2'b11.
- R7: A frame sync that arrives while a frame is in progress restarts both sections at bit 0. It also sets `frame_err`, which stays high until reset.
- R8: When a frame ends without a new sync, the receive section ignores the line and the transmit line is held at 1. A sync that then arrives, at count 20 or later, raises no error.
- R9: After reset, `txd_o` is 1, all transmit readies are 1, all receive valids are 0 and `frame_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lclk_i | input | 1 | Link bit clock from the master |
| fsync_i | input | 1 | Frame sync from the master, high during bit 0 |
| rxd_i | input | 1 | Serial receive data |
| txd_o | output | 1 | Serial transmit data |
| b1_rx_data | output | 8 | Received B1 byte |
| b1_rx_valid | output | 1 | B1 byte valid pulse |
| b2_rx_data | output | 8 | Received B2 byte |
| b2_rx_valid | output | 1 | B2 byte valid pulse |
| d_rx_bits | output | 2 | Received D pair {first, second} |
| d_rx_valid | output | 1 | D pair valid pulse |
| b1_tx_data | input | 8 | B1 byte to send |
| b1_tx_valid | input | 1 | B1 byte offered |
| b1_tx_ready | output | 1 | B1 staging register empty |
| b2_tx_data | input | 8 | B2 byte to send |
| b2_tx_valid | input | 1 | B2 byte offered |
| b2_tx_ready | output | 1 | B2 staging register empty |
| d_tx_bits | input | 2 | D pair to send {first, second} |
| d_tx_valid | input | 1 | D pair offered |
| d_tx_ready | output | 1 | D staging register empty |
| frame_err | output | 1 | Sticky mid-frame sync flag |

## Verification
A wrong receive slot or bit index shows up within one frame. Bytes arrive shifted or swapped against the scoreboard, or the D pair carries bits of a B channel. A transmit state error shows in the 20 captured bits of that same frame, either as misplaced data or as reserved or idle bits not at 1. A staging register that fails to clear or to fill shows at its ready port within one frame, and in the next frame as an all-ones channel where a staged byte belongs. A framing counter that is off by one shows as a false `frame_err` at the next sync.

// File: rtl/idl_pkg.sv
package idl_pkg;
    localparam int B_W     = 8;
    localparam int D_W     = 2;
    localparam int RSV_W   = 2;
    localparam int FRAME_W = 2 * B_W + D_W + RSV_W;
    localparam int IDX_W   = $clog2(B_W);

    typedef enum logic [2:0] {
        SL_WAIT,
        SL_B1,
        SL_D1,
        SL_B2,
        SL_D2,
        SL_RSV
    } slot_e;

    typedef struct packed {
        slot_e             slot;
        logic [IDX_W-1:0]  idx;
    } pos_t;

    // position of the bit that follows p
    function automatic pos_t pos_next(pos_t p);
        pos_t n;
        n = p;
        unique case (p.slot)
            SL_WAIT: n = p;
            SL_B1: begin
                if (p.idx == IDX_W'(B_W - 1)) begin
                    n.slot = SL_D1;
                    n.idx  = '0;
                end else begin
                    n.idx = p.idx + 1'b1;
                end
            end
            SL_D1: begin
                n.slot = SL_B2;
                n.idx  = '0;
            end
            SL_B2: begin
                if (p.idx == IDX_W'(B_W - 1)) begin
                    n.slot = SL_D2;
                    n.idx  = '0;
                end else begin
                    n.idx = p.idx + 1'b1;
                end
            end
            SL_D2: begin
                n.slot = SL_RSV;
                n.idx  = '0;
            end
            SL_RSV: begin
                if (p.idx == IDX_W'(RSV_W - 1)) begin
                    n.slot = SL_WAIT;
                    n.idx  = '0;
                end else begin
                    n.idx = p.idx + 1'b1;
                end
            end
            default: n = p;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/idl_edge_det.sv
module idl_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lclk_i,
    input  logic fsync_i,
    input  logic rxd_i,
    output logic lrise,
    output logic lfall,
    output logic fsync_s,
    output logic rxd_s
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [2:0] stg [SYNC_STAGES];
    logic       lclk_q;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= {lclk_i, fsync_i, rxd_i};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lclk_q <= 1'b0;
        else        lclk_q <= stg[LAST][2];
    end

    assign lrise   =  stg[LAST][2] & ~lclk_q;
    assign lfall   = ~stg[LAST][2] &  lclk_q;
    assign fsync_s =  stg[LAST][1];
    assign rxd_s   =  stg[LAST][0];
endmodule

// File: rtl/idl_stage.sv
module idl_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         take,
    output logic [W-1:0] out_data
);
    logic         full;
    logic [W-1:0] hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            hold <= '0;
        end else if (in_valid && !full) begin
            hold <= in_data;
            full <= 1'b1;
        end else if (take && full) begin
            full <= 1'b0;
        end
    end

    assign in_ready = !full;
    assign out_data = full ? hold : '1;
endmodule

// File: rtl/idl_rx.sv
module idl_rx
    import idl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lfall,
    input  logic           fsync,
    input  logic           rxd,
    output logic [B_W-1:0] b1_data,
    output logic           b1_valid,
    output logic [B_W-1:0] b2_data,
    output logic           b2_valid,
    output logic [D_W-1:0] d_bits,
    output logic           d_valid,
    output logic           err
);
    pos_t           state;
    pos_t           cur;
    pos_t           nxt;
    logic [B_W-1:0] sh;
    logic [D_W-1:0] dreg;

    always_comb begin
        cur = state;
        if (fsync) begin
            cur.slot = SL_B1;
            cur.idx  = '0;
        end
        nxt = pos_next(cur);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)     state <= '{slot: SL_WAIT, idx: '0};
        else if (lfall) state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            dreg     <= '0;
            b1_data  <= '0;
            b2_data  <= '0;
            d_bits   <= '0;
            b1_valid <= 1'b0;
            b2_valid <= 1'b0;
            d_valid  <= 1'b0;
            err      <= 1'b0;
        end else begin
            b1_valid <= 1'b0;
            b2_valid <= 1'b0;
            d_valid  <= 1'b0;
            err      <= 1'b0;
            if (lfall) begin
                err <= fsync && (state.slot != SL_WAIT);
                unique case (cur.slot)
                    SL_WAIT: ;
                    SL_B1: begin
                        sh <= {sh[B_W-2:0], rxd};
                        if (cur.idx == IDX_W'(B_W - 1)) begin
                            b1_data  <= {sh[B_W-2:0], rxd};
                            b1_valid <= 1'b1;
                        end
                    end
                    SL_D1: dreg[1] <= rxd;
                    SL_B2: begin
                        sh <= {sh[B_W-2:0], rxd};
                        if (cur.idx == IDX_W'(B_W - 1)) begin
                            b2_data  <= {sh[B_W-2:0], rxd};
                            b2_valid <= 1'b1;
                        end
                    end
                    SL_D2: dreg[0] <= rxd;
                    SL_RSV: begin
                        if (cur.idx == IDX_W'(RSV_W - 1)) begin
                            d_bits  <= dreg;
                            d_valid <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/idl_tx.sv
module idl_tx
    import idl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lrise,
    input  logic           fsync,
    input  logic [B_W-1:0] b1_data,
    input  logic           b1_valid,
    output logic           b1_ready,
    input  logic [B_W-1:0] b2_data,
    input  logic           b2_valid,
    output logic           b2_ready,
    input  logic [D_W-1:0] d_bits,
    input  logic           d_valid,
    output logic           d_ready,
    output logic           txd,
    output logic           err
);
    pos_t               state;
    pos_t               cur;
    pos_t               nxt;
    logic               start;
    logic [B_W-1:0]     b1_out;
    logic [B_W-1:0]     b2_out;
    logic [D_W-1:0]     d_out;
    logic [FRAME_W-1:0] word;
    logic [FRAME_W-1:0] sh;

    assign start = lrise & fsync;

    idl_stage #(.W(B_W)) u_b1 (
        .clk(clk), .rst_n(rst_n), .in_data(b1_data), .in_valid(b1_valid),
        .in_ready(b1_ready), .take(start), .out_data(b1_out)
    );
    idl_stage #(.W(B_W)) u_b2 (
        .clk(clk), .rst_n(rst_n), .in_data(b2_data), .in_valid(b2_valid),
        .in_ready(b2_ready), .take(start), .out_data(b2_out)
    );
    idl_stage #(.W(D_W)) u_d (
        .clk(clk), .rst_n(rst_n), .in_data(d_bits), .in_valid(d_valid),
        .in_ready(d_ready), .take(start), .out_data(d_out)
    );

    assign word = {b1_out, d_out[1], b2_out, d_out[0], {RSV_W{1'b1}}};

    always_comb begin
        cur = state;
        if (fsync) begin
            cur.slot = SL_B1;
            cur.idx  = '0;
        end
        nxt = pos_next(cur);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)     state <= '{slot: SL_WAIT, idx: '0};
        else if (lrise) state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd <= 1'b1;
            sh  <= '1;
            err <= 1'b0;
        end else begin
            err <= start && (state.slot != SL_WAIT);
            if (lrise) begin
                unique case (cur.slot)
                    SL_WAIT: txd <= 1'b1;
                    SL_B1, SL_D1, SL_B2, SL_D2, SL_RSV: begin
                        if (start) begin
                            txd <= word[FRAME_W-1];
                            sh  <= {word[FRAME_W-2:0], 1'b1};
                        end else begin
                            txd <= sh[FRAME_W-1];
                            sh  <= {sh[FRAME_W-2:0], 1'b1};
                        end
                    end
                    default: txd <= 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/idl_slave_if.sv
module idl_slave_if
    import idl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lclk_i,
    input  logic           fsync_i,
    input  logic           rxd_i,
    output logic           txd_o,
    output logic [B_W-1:0] b1_rx_data,
    output logic           b1_rx_valid,
    output logic [B_W-1:0] b2_rx_data,
    output logic           b2_rx_valid,
    output logic [D_W-1:0] d_rx_bits,
    output logic           d_rx_valid,
    input  logic [B_W-1:0] b1_tx_data,
    input  logic           b1_tx_valid,
    output logic           b1_tx_ready,
    input  logic [B_W-1:0] b2_tx_data,
    input  logic           b2_tx_valid,
    output logic           b2_tx_ready,
    input  logic [D_W-1:0] d_tx_bits,
    input  logic           d_tx_valid,
    output logic           d_tx_ready,
    output logic           frame_err
);
    logic lrise;
    logic lfall;
    logic fsync_s;
    logic rxd_s;
    logic rx_err;
    logic tx_err;

    idl_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .lclk_i(lclk_i), .fsync_i(fsync_i),
        .rxd_i(rxd_i), .lrise(lrise), .lfall(lfall), .fsync_s(fsync_s),
        .rxd_s(rxd_s)
    );

    idl_rx u_rx (
        .clk(clk), .rst_n(rst_n), .lfall(lfall), .fsync(fsync_s), .rxd(rxd_s),
        .b1_data(b1_rx_data), .b1_valid(b1_rx_valid),
        .b2_data(b2_rx_data), .b2_valid(b2_rx_valid),
        .d_bits(d_rx_bits), .d_valid(d_rx_valid), .err(rx_err)
    );

    idl_tx u_tx (
        .clk(clk), .rst_n(rst_n), .lrise(lrise), .fsync(fsync_s),
        .b1_data(b1_tx_data), .b1_valid(b1_tx_valid), .b1_ready(b1_tx_ready),
        .b2_data(b2_tx_data), .b2_valid(b2_tx_valid), .b2_ready(b2_tx_ready),
        .d_bits(d_tx_bits), .d_valid(d_tx_valid), .d_ready(d_tx_ready),
        .txd(txd_o), .err(tx_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) frame_err <= 1'b0;
        else        frame_err <= frame_err | rx_err | tx_err;
    end
endmodule

// File: rtl/idl_slave_if_chk.sv
module idl_slave_if_chk (
    input logic clk,
    input logic rst_n,
    input logic lrise,
    input logic lfall,
    input logic txd_o,
    input logic b1_rx_valid,
    input logic b2_rx_valid,
    input logic d_rx_valid,
    input logic b1_tx_valid,
    input logic b1_tx_ready,
    input logic b2_tx_valid,
    input logic b2_tx_ready,
    input logic frame_err
);
    AST_TXD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd_o) |-> $past(lrise)); // R4

    AST_RXV_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (b1_rx_valid || b2_rx_valid || d_rx_valid) |-> $past(lfall)); // R2

    AST_RXV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({b1_rx_valid, b2_rx_valid, d_rx_valid})); // R3

    AST_B1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (b1_tx_valid && b1_tx_ready) |=> !b1_tx_ready); // R5

    AST_B2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (b2_tx_valid && b2_tx_ready) |=> !b2_tx_ready); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err); // R7
endmodule

bind idl_slave_if idl_slave_if_chk u_chk (.*);

// File: tb/tb_idl_slave_if.sv
module tb_idl_slave_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lclk_i = 1'b0, fsync_i = 1'b0, rxd_i = 1'b0;
    logic       txd_o;
    logic [7:0] b1_rx_data, b2_rx_data;
    logic       b1_rx_valid, b2_rx_valid, d_rx_valid;
    logic [1:0] d_rx_bits;
    logic [7:0] b1_tx_data = '0, b2_tx_data = '0;
    logic       b1_tx_valid = 1'b0, b2_tx_valid = 1'b0, d_tx_valid = 1'b0;
    logic [1:0] d_tx_bits = '0;
    logic       b1_tx_ready, b2_tx_ready, d_tx_ready;
    logic       frame_err;

    int errors = 0;
    int checks = 0;
    logic [9:0] exp_q[$];   // {kind, data}: 0=B1, 1=B2, 2=D

    always #10 clk = ~clk;  // 50 MHz

    idl_slave_if dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] mk(input logic [7:0] b1, input logic d1,
                                       input logic [7:0] b2, input logic d2,
                                       input logic [1:0] rsv);
        return {b1, d1, b2, d2, rsv};
    endfunction

    // one link bit: data set in low phase, rise, capture tx before fall
    task automatic link_bit(input logic b, input logic s, output logic txb);
        @(negedge clk);
        rxd_i = b; fsync_i = s;
        repeat (8) @(negedge clk);
        lclk_i = 1'b1;
        repeat (8) @(negedge clk);
        txb = txd_o;
        lclk_i = 1'b0;
    endtask

    task automatic run_bits(input logic [19:0] w, input logic sync, input int n,
                            output logic [19:0] txw);
        logic tb;
        txw = '1;
        for (int i = 0; i < n; i++) begin
            link_bit(w[19-i], sync && (i == 0), tb);
            txw[19-i] = tb;
        end
        @(negedge clk);
        fsync_i = 1'b0;
    endtask

    task automatic expect_frame(input logic [19:0] w);
        exp_q.push_back({2'd0, w[19:12]});
        exp_q.push_back({2'd1, w[10:3]});
        exp_q.push_back({2'd2, 6'd0, w[11], w[2]});
    endtask

    task automatic stage(input int ch, input logic [7:0] v);
        @(negedge clk);
        if (ch == 0) begin b1_tx_data = v; b1_tx_valid = 1'b1; end
        else if (ch == 1) begin b2_tx_data = v; b2_tx_valid = 1'b1; end
        else begin d_tx_bits = v[1:0]; d_tx_valid = 1'b1; end
        @(negedge clk);
        b1_tx_valid = 1'b0; b2_tx_valid = 1'b0; d_tx_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (b1_rx_valid || b2_rx_valid || d_rx_valid)) begin
            logic [9:0] got;
            if (b1_rx_valid)      got = {2'd0, b1_rx_data};
            else if (b2_rx_valid) got = {2'd1, b2_rx_data};
            else                  got = {2'd2, 6'd0, d_rx_bits};
            if (exp_q.size() == 0) begin
                check("R1/R2/R3 unexpected rx item", 32'(got), 32'h3ff);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                check(e[9:8] == 2'd2 ? "R3 rx D pair" : "R1/R2 rx byte",
                      32'(got), 32'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [19:0] txw;
        logic [19:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 txd idle", 32'(txd_o), 32'd1);
        check("R9 readies", 32'({b1_tx_ready, b2_tx_ready, d_tx_ready}), 32'd7);
        check("R9 valids", 32'({b1_rx_valid, b2_rx_valid, d_rx_valid}), 32'd0);
        check("R9 frame_err", 32'(frame_err), 32'd0);

        // frame A: nothing staged -> all ones (R6); rx layout (R1)
        w = mk(8'hA5, 1'b1, 8'h3C, 1'b0, 2'b01);
        expect_frame(w);
        run_bits(w, 1'b1, 20, txw);
        check("R6 empty frame all ones", 32'(txw), 32'hFFFFF);

        // frame B: all channels staged (R5, R4)
        stage(0, 8'h12); stage(1, 8'h80); stage(2, 8'h01);
        check("R5 readies low while staged",
              32'({b1_tx_ready, b2_tx_ready, d_tx_ready}), 32'd0);
        w = mk(8'h5A, 1'b0, 8'hC3, 1'b1, 2'b10);
        expect_frame(w);
        run_bits(w, 1'b1, 20, txw);
        check("R4 tx layout", 32'(txw), 32'(mk(8'h12, 1'b0, 8'h80, 1'b1, 2'b11)));
        check("R5 readies back high",
              32'({b1_tx_ready, b2_tx_ready, d_tx_ready}), 32'd7);

        // frame C: only B2 staged (R6), reserved rx ones ignored (R1)
        stage(1, 8'h00);
        w = mk(8'h00, 1'b1, 8'hFF, 1'b1, 2'b11);
        expect_frame(w);
        run_bits(w, 1'b1, 20, txw);
        check("R6 B1 fill / D fill", 32'(txw), 32'(mk(8'hFF, 1'b1, 8'h00, 1'b1, 2'b11)));

        // idle bits without sync (R8)
        run_bits(20'h55555, 1'b0, 3, txw);
        check("R8 idle tx ones", 32'(txw[19:17]), 32'd7);
        w = mk(8'h81, 1'b0, 8'h7E, 1'b0, 2'b00);
        expect_frame(w);
        run_bits(w, 1'b1, 20, txw);
        check("R8 late sync no error", 32'(frame_err), 32'd0);
        check("R6 tx after idle", 32'(txw), 32'hFFFFF);

        // mid-frame sync (R7)
        w = mk(8'hC5, 1'b1, 8'hAA, 1'b0, 2'b00);
        exp_q.push_back({2'd0, 8'hC5});
        run_bits(w, 1'b1, 10, txw);
        w = mk(8'h33, 1'b1, 8'h44, 1'b0, 2'b01);
        expect_frame(w);
        run_bits(w, 1'b1, 20, txw);
        check("R7 frame_err set", 32'(frame_err), 32'd1);
        check("R7 tx restart", 32'(txw), 32'hFFFFF);
        w = mk(8'hE7, 1'b0, 8'h18, 1'b1, 2'b00);
        expect_frame(w);
        run_bits(w, 1'b1, 20, txw);
        check("R7 frame_err sticky", 32'(frame_err), 32'd1);

        repeat (20) @(negedge clk);
        check("R2/R3 all rx items delivered", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule